// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes 8-bit frames from a serial line that travels with its own bit clock. Each frame arrives least significant bit first, one bit per rising edge of the bit clock. Two sources can supply that clock. In internal mode the block divides the system clock and drives the bit clock out to the sender. In external mode the bit clock comes in on a pin and passes through a synchronizer into the system clock domain. The data line always passes through a synchronizer of the same depth.

When a frame completes, the assembled word is copied into a holding register and a full flag is set. If a frame completes while the full flag is still set, the block records an overrun. In that case the new word is dropped and the holding register and the full flag keep their values. While an overrun, a framing error or a parity error is present, the block ignores incoming bits. Software clears the flags through a write strobe and can enable two level interrupts: one for data available and one for errors.

Top module: `csync_rx`

## Requirements
- R1: When the eighth bit of a frame is taken and the full flag is 0, the word is loaded into `rx_data` and `rx_full` becomes 1. Bit 0 of the word is the first bit received.
- R2: When the eighth bit of a frame is taken and `rx_full` is 1, `rx_ovr` becomes 1. `rx_data` keeps its previous value and `rx_full` stays 1.
- R3: `irq_rx` is 1 exactly when `rie` is 1, `rx_full` is 1 and `rx_ovr` is 0.
- R4: `irq_err` is 1 exactly when `rie` is 1 and at least one of `rx_ovr`, `fer_in` or `per_in` is 1.
- R5: While `rx_ovr`, `fer_in` or `per_in` is 1, bit-clock edges are ignored. No bit is shifted and no frame completes.
- R6: A cycle with `wr_stat` = 1 updates the flags. `wr_full_v` = 0 clears `rx_full` and `wr_ovr_v` = 0 clears `rx_ovr`; a value of 1 leaves the flag unchanged. If a flag is set by a frame in the same cycle, the set wins.
- R7: With `int_clk_sel` = 1 and `rx_en` = 1, `sclk_out` toggles every `HALF_PERIOD` system clocks without regard to the flags. Otherwise `sclk_out` is held at 1.
- R8: In external mode (`int_clk_sel` = 0), `sclk_in` and `sdata_in` each pass through `SYNC_STAGES` flops. A bit is taken on a rising edge of the synchronized clock, using the synchronized data.
- R9: Setting `rx_en` to 0 discards a partially received frame. The next frame starts again at bit 0.
- R10: After reset, `rx_data` is 0, `rx_full` and `rx_ovr` are 0, and `sclk_out` is 1.
- R11: If `rx_full` is cleared before the next frame completes, back-to-back frames are all received with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| int_clk_sel | input | 1 | 1: bit clock generated internally; 0: bit clock taken from sclk_in |
| sclk_in | input | 1 | External bit clock |
| sclk_out | output | 1 | Internally generated bit clock (idle high) |
| sdata_in | input | 1 | Serial data |
| rie | input | 1 | Receive interrupt enable |
| fer_in | input | 1 | Framing error flag from elsewhere; blocks reception |
| per_in | input | 1 | Parity error flag from elsewhere; blocks reception |
| wr_stat | input | 1 | Flag write strobe |
| wr_full_v | input | 1 | Value written to the full flag (0 clears) |
| wr_ovr_v | input | 1 | Value written to the overrun flag (0 clears) |
| rx_data | output | 8 | Received data register |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| irq_rx | output | 1 | Receive-data interrupt (level) |
| irq_err | output | 1 | Error interrupt (level) |

## Verification
The hardest case is continuous reception in internal mode. There, the block paces the bits, and the full flag must be cleared while the next frame is already arriving. The stimulus tracks the falling edges of `sclk_out` to place each data bit. In the middle of the second frame it issues a clear of `rx_full`, which shows that no overrun occurs. It then stops servicing the block and lets the free-running clock force an overrun. A behavioural model in the bench replays the synchronizer delays and follows every flag and data transition cycle by cycle.

// File: rtl/csync_rx_pkg.sv
package csync_rx_pkg;

    localparam int FRAME_BITS = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] rx_word_t;

    typedef struct packed {
        logic full;
        logic ovr;
    } rx_flags_t;

    typedef struct packed {
        logic     valid;
        rx_word_t word;
    } frame_evt_t;

    // New bit enters at the top; after a full frame the first bit sits at bit 0.
    function automatic rx_word_t push_lsb_first(input rx_word_t sh, input logic b);
        return {b, sh[FRAME_BITS-1:1]};
    endfunction

endpackage

// File: rtl/csync_rx_clkgen.sv
module csync_rx_clkgen #(
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic int_sel,
    input  logic rx_en,
    input  logic sclk_in,
    input  logic sdata_in,
    output logic sclk_out,
    output logic bit_stb,
    output logic bit_val
);

    localparam int DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic [DIV_W-1:0]     div_cnt;
    logic                 sclk_int;
    logic                 sclk_q;
    logic                 running;
    logic [SYNC_STAGES:0] ck_pipe;
    logic [SYNC_STAGES-1:0] dt_pipe;
    logic                 ext_rise;
    logic                 int_rise;

    assign running = int_sel & rx_en;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            div_cnt  <= '0;
            sclk_int <= 1'b1;
        end else if (div_cnt == DIV_W'(HALF_PERIOD - 1)) begin
            div_cnt  <= '0;
            sclk_int <= ~sclk_int;
        end else begin
            div_cnt  <= div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk_int;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_pipe[0] <= 1'b1;
            dt_pipe[0] <= 1'b0;
        end else begin
            ck_pipe[0] <= sclk_in;
            dt_pipe[0] <= sdata_in;
        end
    end

    for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_ck_sync
        always_ff @(posedge clk) begin
            if (rst) ck_pipe[g] <= 1'b1;
            else     ck_pipe[g] <= ck_pipe[g-1];
        end
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_dt_sync
        always_ff @(posedge clk) begin
            if (rst) dt_pipe[g] <= 1'b0;
            else     dt_pipe[g] <= dt_pipe[g-1];
        end
    end

    assign ext_rise = ck_pipe[SYNC_STAGES-1] & ~ck_pipe[SYNC_STAGES];
    assign int_rise = sclk_int & ~sclk_q;
    assign bit_stb  = int_sel ? int_rise : ext_rise;
    assign bit_val  = dt_pipe[SYNC_STAGES-1];
    assign sclk_out = sclk_int;

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        !running |=> sclk_int) else $error("idle bit clock not high"); // R7

endmodule

// File: rtl/csync_rx_shift.sv
module csync_rx_shift
    import csync_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       blocked,
    input  logic       bit_stb,
    input  logic       bit_val,
    output frame_evt_t evt
);

    logic [CNT_W-1:0] cnt;
    rx_word_t         sh;
    logic             take;
    logic             last;

    assign take = rx_en & bit_stb & ~blocked;
    assign last = (cnt == CNT_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            cnt <= '0;
            sh  <= '0;
        end else if (take) begin
            sh  <= push_lsb_first(sh, bit_val);
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    assign evt.valid = take & last;
    assign evt.word  = push_lsb_first(sh, bit_val);

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (cnt == '0)) else $error("partial frame kept"); // R9

    AST_BLOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (blocked && rx_en) |=> $stable(cnt)) else $error("bit taken while blocked"); // R5

endmodule

// File: rtl/csync_rx_flags.sv
module csync_rx_flags
    import csync_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    input  logic       wr_stat,
    input  logic       wr_full_v,
    input  logic       wr_ovr_v,
    input  logic       rie,
    input  logic       ext_err,
    output rx_word_t   rx_data,
    output rx_flags_t  flags,
    output logic       blocked,
    output logic       irq_rx,
    output logic       irq_err
);

    rx_flags_t flags_d;
    rx_word_t  data_d;

    always_comb begin
        flags_d = flags;
        data_d  = rx_data;
        if (wr_stat) begin
            if (!wr_full_v) flags_d.full = 1'b0;
            if (!wr_ovr_v)  flags_d.ovr  = 1'b0;
        end
        if (evt.valid) begin
            if (flags.full) begin
                flags_d.ovr = 1'b1;
            end else begin
                data_d       = evt.word;
                flags_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            rx_data <= '0;
        end else begin
            flags   <= flags_d;
            rx_data <= data_d;
        end
    end

    assign blocked = flags.ovr | ext_err;
    assign irq_rx  = rie & flags.full & ~flags.ovr;
    assign irq_err = rie & (flags.ovr | ext_err);

    AST_OVR_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovr) |-> $stable(rx_data)) else $error("data changed on overrun"); // R2

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovr) |-> $past(flags.full)) else $error("overrun without full"); // R2

    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && !flags.full) |=> (flags.full && rx_data == $past(evt.word)))
        else $error("frame not loaded"); // R1

endmodule

// File: rtl/csync_rx.sv
module csync_rx
    import csync_rx_pkg::*;
#(
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       int_clk_sel,
    input  logic       sclk_in,
    output logic       sclk_out,
    input  logic       sdata_in,
    input  logic       rie,
    input  logic       fer_in,
    input  logic       per_in,
    input  logic       wr_stat,
    input  logic       wr_full_v,
    input  logic       wr_ovr_v,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       rx_ovr,
    output logic       irq_rx,
    output logic       irq_err
);

    logic       bit_stb;
    logic       bit_val;
    logic       blocked;
    frame_evt_t evt;
    rx_flags_t  flags;
    rx_word_t   data_q;

    csync_rx_clkgen #(
        .HALF_PERIOD (HALF_PERIOD),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .int_sel  (int_clk_sel),
        .rx_en    (rx_en),
        .sclk_in  (sclk_in),
        .sdata_in (sdata_in),
        .sclk_out (sclk_out),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val)
    );

    csync_rx_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .rx_en   (rx_en),
        .blocked (blocked),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .evt     (evt)
    );

    csync_rx_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .wr_stat   (wr_stat),
        .wr_full_v (wr_full_v),
        .wr_ovr_v  (wr_ovr_v),
        .rie       (rie),
        .ext_err   (fer_in | per_in),
        .rx_data   (data_q),
        .flags     (flags),
        .blocked   (blocked),
        .irq_rx    (irq_rx),
        .irq_err   (irq_err)
    );

    assign rx_data = data_q;
    assign rx_full = flags.full;
    assign rx_ovr  = flags.ovr;

    AST_IRQ_NOT_ON_OVR: assert property (@(posedge clk) disable iff (rst)
        !(irq_rx && rx_ovr)) else $error("data irq during overrun"); // R3

endmodule

// File: tb/csync_rx_bench.sv
module csync_rx_bench;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       int_clk_sel = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sdata_in = 1'b0;
    logic       rie = 1'b0;
    logic       fer_in = 1'b0;
    logic       per_in = 1'b0;
    logic       wr_stat = 1'b0;
    logic       wr_full_v = 1'b1;
    logic       wr_ovr_v = 1'b1;
    logic       sclk_out;
    logic [7:0] rx_data;
    logic       rx_full, rx_ovr, irq_rx, irq_err;

    int n_vec = 0;
    int n_bad = 0;

    csync_rx u_csync_rx (
        .clk (clk), .rst (rst), .rx_en (rx_en), .int_clk_sel (int_clk_sel),
        .sclk_in (sclk_in), .sclk_out (sclk_out), .sdata_in (sdata_in),
        .rie (rie), .fer_in (fer_in), .per_in (per_in),
        .wr_stat (wr_stat), .wr_full_v (wr_full_v), .wr_ovr_v (wr_ovr_v),
        .rx_data (rx_data), .rx_full (rx_full), .rx_ovr (rx_ovr),
        .irq_rx (irq_rx), .irq_err (irq_err)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic       so_cur = 1'b1;
    logic       so_prev = 1'b1;
    logic       ck_hist [1:3];
    logic       dt_hist [1:2];
    logic [7:0] m_data = 8'h00;
    logic [7:0] m_sh = 8'h00;
    logic       m_full = 1'b0;
    logic       m_ovr = 1'b0;
    int         m_cnt = 0;
    bit         started = 0;

    always @(negedge clk) so_cur = sclk_out;

    always @(posedge clk) begin
        logic pulse, nf, no, blk, b;
        if (rst) begin
            m_data = 8'h00; m_sh = 8'h00; m_full = 1'b0; m_ovr = 1'b0; m_cnt = 0;
            ck_hist[1] = 1'b1; ck_hist[2] = 1'b1; ck_hist[3] = 1'b1;
            dt_hist[1] = 1'b0; dt_hist[2] = 1'b0;
            so_prev = 1'b1;
        end else begin
            nf = m_full; no = m_ovr;
            if (wr_stat) begin
                if (!wr_full_v) nf = 1'b0;
                if (!wr_ovr_v)  no = 1'b0;
            end
            blk   = m_ovr | fer_in | per_in;
            pulse = int_clk_sel ? (so_cur & ~so_prev) : (ck_hist[2] & ~ck_hist[3]);
            b     = dt_hist[2];
            if (!rx_en) begin
                m_cnt = 0;
            end else if (pulse && !blk) begin
                m_sh = {b, m_sh[7:1]};
                if (m_cnt == 7) begin
                    m_cnt = 0;
                    if (m_full) no = 1'b1;
                    else begin m_data = m_sh; nf = 1'b1; end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            m_full = nf; m_ovr = no;
            ck_hist[3] = ck_hist[2]; ck_hist[2] = ck_hist[1]; ck_hist[1] = sclk_in;
            dt_hist[2] = dt_hist[1]; dt_hist[1] = sdata_in;
            so_prev = so_cur;
        end
        started = 1;
    end

    // cycle-by-cycle comparison, away from the edge
    int   run_len = 0;
    bit   run_ok = 0;
    logic run_last = 1'b1;

    initial forever begin
        @(posedge clk);
        #3;
        if (started) begin
            check("R1 R8 rx_data", rx_data, m_data);
            check("R1 rx_full", {7'd0, rx_full}, {7'd0, m_full});
            check("R2 rx_ovr", {7'd0, rx_ovr}, {7'd0, m_ovr});
            check("R3 irq_rx", {7'd0, irq_rx}, {7'd0, rie & m_full & ~m_ovr});
            check("R4 irq_err", {7'd0, irq_err}, {7'd0, rie & (m_ovr | fer_in | per_in)});
            if (!(int_clk_sel && rx_en) || rst) begin
                check("R7 idle sclk_out", {7'd0, sclk_out}, 8'd1);
                run_ok = 0; run_len = 0; run_last = 1'b1;
            end else if (sclk_out !== run_last) begin
                if (run_ok) check("R7 half period", run_len[7:0], 8'(HALF));
                run_ok = 1; run_len = 1; run_last = sclk_out;
            end else begin
                run_len++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_flags(input logic fv, input logic ov);
        @(negedge clk);
        wr_stat = 1'b1; wr_full_v = fv; wr_ovr_v = ov;
        @(negedge clk);
        wr_stat = 1'b0; wr_full_v = 1'b1; wr_ovr_v = 1'b1;
    endtask

    task automatic ext_bit(input logic v);
        @(negedge clk);
        sclk_in = 1'b0; sdata_in = v;
        repeat (3) @(negedge clk);
        sclk_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ext_frame(input logic [7:0] w);
        for (int i = 0; i < 8; i++) ext_bit(w[i]);
        settle(4);
    endtask

    task automatic int_frame(input logic [7:0] w, input bit clr, input logic [7:0] prev);
        for (int i = 0; i < 8; i++) begin
            while (sclk_out !== 1'b1) @(negedge clk);
            @(negedge clk);
            while (sclk_out !== 1'b0) @(negedge clk);
            sdata_in = w[i];
            if (clr && i == 2) begin
                #1;
                check("R11 previous word held before clear", rx_data, prev);
                wr_stat = 1'b1; wr_full_v = 1'b0; wr_ovr_v = 1'b1;
                @(negedge clk);
                wr_stat = 1'b0; wr_full_v = 1'b1;
            end
        end
        while (sclk_out !== 1'b1) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle(1);
        check("R10 reset data", rx_data, 8'h00);
        check("R10 reset flags", {6'd0, rx_full, rx_ovr}, 8'd0);
        check("R10 reset sclk_out", {7'd0, sclk_out}, 8'd1);

        // external mode
        rie = 1'b1; rx_en = 1'b1;
        ext_frame(8'hA5);
        check("R1 R8 first word", rx_data, 8'hA5);
        check("R3 irq_rx on full", {7'd0, irq_rx}, 8'd1);

        ext_frame(8'h3C);
        check("R2 data kept on overrun", rx_data, 8'hA5);
        check("R2 ovr set", {6'd0, rx_full, rx_ovr}, 8'd3);
        check("R4 irq_err on overrun", {6'd0, irq_rx, irq_err}, 8'd1);

        ext_frame(8'hFF);
        check("R5 frame ignored during overrun", rx_data, 8'hA5);

        wr_flags(1'b1, 1'b0);
        settle(1);
        check("R6 ovr cleared, full kept", {6'd0, rx_full, rx_ovr}, 8'd2);
        wr_flags(1'b0, 1'b1);
        settle(1);
        check("R6 full cleared", {6'd0, rx_full, rx_ovr}, 8'd0);

        ext_frame(8'h81);
        check("R5 reception resumes after clear", rx_data, 8'h81);
        wr_flags(1'b0, 1'b1);

        fer_in = 1'b1;
        settle(1);
        check("R4 irq_err on framing error", {7'd0, irq_err}, 8'd1);
        ext_frame(8'h55);
        check("R5 framing error blocks", {rx_data[6:0], rx_full}, {7'h01, 1'b0});
        fer_in = 1'b0;

        per_in = 1'b1;
        settle(1);
        check("R4 irq_err on parity error", {7'd0, irq_err}, 8'd1);
        ext_frame(8'h77);
        check("R5 parity error blocks", {7'd0, rx_full}, 8'd0);
        per_in = 1'b0;

        ext_frame(8'h12);
        check("R1 word after errors", rx_data, 8'h12);
        wr_flags(1'b0, 1'b1);

        // partial frame then disable
        for (int i = 0; i < 4; i++) ext_bit(1'b1);
        @(negedge clk); rx_en = 1'b0;
        repeat (2) @(negedge clk); rx_en = 1'b1;
        ext_frame(8'h6E);
        check("R9 partial frame discarded", rx_data, 8'h6E);
        check("R9 full after fresh frame", {7'd0, rx_full}, 8'd1);
        wr_flags(1'b0, 1'b1);

        // internal mode, continuous reception
        rie = 1'b0;
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); int_clk_sel = 1'b1; rx_en = 1'b1;
        int_frame(8'hC3, 0, 8'h00);
        int_frame(8'h5A, 1, 8'hC3);
        settle(3);
        check("R11 second word", rx_data, 8'h5A);
        check("R11 no overrun", {6'd0, rx_full, rx_ovr}, 8'd2);
        check("R3 irq_rx masked", {7'd0, irq_rx}, 8'd0);

        // unserviced free-running clock forces overrun
        sdata_in = 1'b0;
        settle(150);
        check("R7 free run overruns", {6'd0, rx_full, rx_ovr}, 8'd3);
        check("R2 data held after free-run overrun", rx_data, 8'h5A);
        check("R4 irq_err masked", {7'd0, irq_err}, 8'd0);

        rx_en = 1'b0;
        settle(2);
        check("R7 clock stops when disabled", {7'd0, sclk_out}, 8'd1);
        settle(10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule